// File: doc/BRIEF.md
# Trap Return State Update Unit

This unit carries out the two trap-return instructions of a processor core: the return from a machine-level handler and the return from a supervisor-level handler. The core presents one request per cycle with the kind of return, the current privilege level and virtualization state, the machine and hypervisor status words, both exception program counters and a handful of configuration strapping flags. The unit decides whether the return is legal. It then produces either the rewritten status words together with the new privilege, the new virtualization state and the PC to resume at, or an exception pulse carrying a cause code.

All results are registered and appear one clock after the request. When a return is refused, the status, privilege and virtualization outputs echo the request's inputs, so the core can write them back without a special case. Exchanging the banked hypervisor registers is left to the core. The unit only raises a one-cycle swap request when a return re-enters a virtualized context.

Privilege is encoded as 0 for user, 1 for supervisor and 3 for machine. Exception causes are 0 (return address misaligned), 1 (instruction access fault), 2 (illegal instruction) and 22 (virtual instruction). Machine status bit positions: 1 supervisor IE, 3 machine IE, 5 supervisor prior-IE, 7 machine prior-IE, 8 supervisor prior-privilege, 12:11 machine prior-privilege, 17 modify-privilege, 22 supervisor-return trap, 39 machine prior-virtualization. Hypervisor status bit positions: 7 supervisor prior-virtualization, 22 virtual supervisor-return trap. A request with `req_kind` = 1 is a machine return and 0 is a supervisor return.

Top module: `trap_return_unit`

## Requirements
- R1: A supervisor return issued at user privilege (0) raises cause 2, whatever the other inputs are.
- R2: When `cfg_compressed` is 0 and the selected return PC (mepc for machine, sepc for supervisor) has either bit 1 or bit 0 set, the return raises cause 0. This check ranks below the privilege check and above every other check. When `cfg_compressed` is 1, the low bits are not checked.
- R3: A supervisor return raises cause 2 when machine status bit 22 is set and privilege is not 3. Otherwise it raises cause 22 when `cfg_hyp` is 1, `cur_virt` is 1 and hypervisor status bit 22 is set.
- R4: A successful supervisor return sets bit 1 from the old bit 5, sets bit 5 to 1 and clears bit 8. It clears bit 17 when `cfg_new_spec` is 1. The new privilege is {0, old bit 8} and `ret_pc` is sepc.
- R5: On a successful supervisor return with `cfg_hyp` = 1 and `cur_virt` = 0, the new virtualization state is hypervisor status bit 7. That bit is cleared, and `swap_req` pulses if it was 1. In any other case, the hypervisor status and virtualization state pass through and `swap_req` stays low.
- R6: A machine return at a privilege other than 3 raises cause 2.
- R7: A successful machine return sets bit 3 from the old bit 7, sets bit 7 to 1, clears bits 12:11 and clears bit 39. The new privilege is the old bits 12:11 and `ret_pc` is mepc.
- R8: A successful machine return clears bit 17 only when `cfg_new_spec` is 1 and the old bits 12:11 are not 3. Otherwise bit 17 is kept.
- R9: On a successful machine return with `cfg_hyp` = 1, the new virtualization state is the old bit 39, and `swap_req` pulses when that bit was 1. With `cfg_hyp` = 0, virtualization is unchanged and no swap is requested.
- R10: A machine return raises cause 1 when `cfg_pmp` is 1, `cfg_pmp_rules` is 0 and the old bits 12:11 are not 3. This check ranks below the misalignment check.
- R11: On an exception, `exc_valid` pulses for one cycle and `ret_valid` stays low. The status, privilege and virtualization outputs equal the request's inputs.
- R12: After reset, all pulses are low, `priv_out` is 3 and every other output is 0.
- R13: Without `req_valid`, no pulse is produced and all state outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one return per cycle |
| req_kind | input | 1 | 1 = machine return, 0 = supervisor return |
| cur_priv | input | 2 | Current privilege level |
| cur_virt | input | 1 | Current virtualization state |
| mstatus_in | input | XLEN | Machine status word |
| hstatus_in | input | XLEN | Hypervisor status word |
| mepc_in | input | XLEN | Machine exception PC |
| sepc_in | input | XLEN | Supervisor exception PC |
| cfg_compressed | input | 1 | Compressed instructions supported |
| cfg_hyp | input | 1 | Hypervisor support present |
| cfg_pmp | input | 1 | Physical memory protection present |
| cfg_pmp_rules | input | RULE_W | Number of configured protection rules |
| cfg_new_spec | input | 1 | Privileged spec version 1.12 or later |
| ret_valid | output | 1 | One-cycle pulse: return accepted |
| ret_pc | output | XLEN | PC to resume at |
| mstatus_out | output | XLEN | Updated machine status word |
| hstatus_out | output | XLEN | Updated hypervisor status word |
| priv_out | output | 2 | New privilege level |
| virt_out | output | 1 | New virtualization state |
| swap_req | output | 1 | One-cycle pulse: exchange hypervisor register banks |
| exc_valid | output | 1 | One-cycle pulse: return refused |
| exc_cause | output | 5 | Exception cause code |

## Verification
The bench builds the unit with XLEN = 64 and RULE_W = 7. This puts the machine prior-virtualization bit at position 39 inside the word, so its restore and clear can be observed. It also allows a nonzero rule count to be set against the empty-rule fault. Each vector pairs a stimulus with its expected cause. This brings the priority between refusals within reach: a misaligned PC at low privilege, a set trap bit together with a virtual trap bit, and a misaligned PC when the rule count is zero.

// File: rtl/trp_pkg.sv
package trp_pkg;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  typedef enum logic [4:0] {
    CAUSE_MISALIGN = 5'd0,
    CAUSE_ACCESS   = 5'd1,
    CAUSE_ILLEGAL  = 5'd2,
    CAUSE_VIRT     = 5'd22
  } cause_e;

  typedef enum logic {
    RET_SUP  = 1'b0,
    RET_MACH = 1'b1
  } ret_kind_e;

  // Machine status bit positions
  localparam int ST_SUP_IE    = 1;
  localparam int ST_MACH_IE   = 3;
  localparam int ST_SUP_PIE   = 5;
  localparam int ST_MACH_PIE  = 7;
  localparam int ST_SUP_PP    = 8;
  localparam int ST_MACH_PP   = 11;
  localparam int ST_MOD_PRIV  = 17;
  localparam int ST_TRAP_SRET = 22;
  localparam int ST_MACH_PV   = 39;

  // Hypervisor status bit positions
  localparam int HY_SUP_PV    = 7;
  localparam int HY_VTRAP_SR  = 22;

endpackage

// File: rtl/trp_gate.sv
module trp_gate
  import trp_pkg::*;
#(
  parameter int RULE_W = 7
) (
  input  logic              kind_mach,
  input  logic [1:0]        priv,
  input  logic              virt,
  input  logic              trap_sret,
  input  logic [1:0]        mach_pp,
  input  logic              vtrap_sret,
  input  logic [1:0]        epc_lo,
  input  logic              cfg_compressed,
  input  logic              cfg_hyp,
  input  logic              cfg_pmp,
  input  logic [RULE_W-1:0] cfg_pmp_rules,
  output logic              fault,
  output cause_e            cause
);

  logic misaligned;
  logic no_rules;

  assign misaligned = !cfg_compressed && (epc_lo != 2'b00);
  assign no_rules   = (cfg_pmp_rules == '0);

  // Ordered refusal chain; first match wins
  always_comb begin
    fault = 1'b0;
    cause = CAUSE_ILLEGAL;
    if (!kind_mach) begin
      if (priv < PRIV_S) begin
        fault = 1'b1;
        cause = CAUSE_ILLEGAL;
      end else if (misaligned) begin
        fault = 1'b1;
        cause = CAUSE_MISALIGN;
      end else if (trap_sret && (priv != PRIV_M)) begin
        fault = 1'b1;
        cause = CAUSE_ILLEGAL;
      end else if (cfg_hyp && virt && vtrap_sret) begin
        fault = 1'b1;
        cause = CAUSE_VIRT;
      end
    end else begin
      if (priv != PRIV_M) begin
        fault = 1'b1;
        cause = CAUSE_ILLEGAL;
      end else if (misaligned) begin
        fault = 1'b1;
        cause = CAUSE_MISALIGN;
      end else if (cfg_pmp && no_rules && (mach_pp != PRIV_M)) begin
        fault = 1'b1;
        cause = CAUSE_ACCESS;
      end
    end
  end

endmodule

// File: rtl/trp_sret_next.sv
module trp_sret_next
  import trp_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] ms,
  input  logic [XLEN-1:0] hs,
  input  logic            virt,
  input  logic            cfg_hyp,
  input  logic            cfg_new_spec,
  output logic [XLEN-1:0] ms_next,
  output logic [XLEN-1:0] hs_next,
  output logic [1:0]      priv_next,
  output logic            virt_next,
  output logic            swap
);

  always_comb begin
    ms_next               = ms;
    ms_next[ST_SUP_IE]    = ms[ST_SUP_PIE];
    ms_next[ST_SUP_PIE]   = 1'b1;
    ms_next[ST_SUP_PP]    = 1'b0;
    if (cfg_new_spec) ms_next[ST_MOD_PRIV] = 1'b0;
    priv_next             = {1'b0, ms[ST_SUP_PP]};

    hs_next   = hs;
    virt_next = virt;
    swap      = 1'b0;
    if (cfg_hyp && !virt) begin
      virt_next          = hs[HY_SUP_PV];
      hs_next[HY_SUP_PV] = 1'b0;
      swap               = hs[HY_SUP_PV];
    end
  end

endmodule

// File: rtl/trp_mret_next.sv
module trp_mret_next
  import trp_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] ms,
  input  logic            virt,
  input  logic            cfg_hyp,
  input  logic            cfg_new_spec,
  output logic [XLEN-1:0] ms_next,
  output logic [1:0]      priv_next,
  output logic            virt_next,
  output logic            swap
);

  logic [1:0] old_pp;
  assign old_pp = ms[ST_MACH_PP+1:ST_MACH_PP];

  always_comb begin
    ms_next                             = ms;
    ms_next[ST_MACH_IE]                 = ms[ST_MACH_PIE];
    ms_next[ST_MACH_PIE]                = 1'b1;
    ms_next[ST_MACH_PP+1:ST_MACH_PP]    = PRIV_U;
    ms_next[ST_MACH_PV]                 = 1'b0;
    if (cfg_new_spec && (old_pp != PRIV_M)) ms_next[ST_MOD_PRIV] = 1'b0;
    priv_next = old_pp;

    virt_next = virt;
    swap      = 1'b0;
    if (cfg_hyp) begin
      virt_next = ms[ST_MACH_PV];
      swap      = ms[ST_MACH_PV];
    end
  end

endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
  import trp_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int RULE_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_kind,
  input  logic [1:0]        cur_priv,
  input  logic              cur_virt,
  input  logic [XLEN-1:0]   mstatus_in,
  input  logic [XLEN-1:0]   hstatus_in,
  input  logic [XLEN-1:0]   mepc_in,
  input  logic [XLEN-1:0]   sepc_in,
  input  logic              cfg_compressed,
  input  logic              cfg_hyp,
  input  logic              cfg_pmp,
  input  logic [RULE_W-1:0] cfg_pmp_rules,
  input  logic              cfg_new_spec,
  output logic              ret_valid,
  output logic [XLEN-1:0]   ret_pc,
  output logic [XLEN-1:0]   mstatus_out,
  output logic [XLEN-1:0]   hstatus_out,
  output logic [1:0]        priv_out,
  output logic              virt_out,
  output logic              swap_req,
  output logic              exc_valid,
  output logic [4:0]        exc_cause
);

  localparam int PP_HI = ST_MACH_PP + 1;

  logic            is_mach;
  logic [XLEN-1:0] sel_epc;
  logic            fault;
  cause_e          cause;

  logic [XLEN-1:0] s_ms, s_hs, m_ms;
  logic [1:0]      s_priv, m_priv;
  logic            s_virt, m_virt, s_swap, m_swap;

  assign is_mach = (req_kind == RET_MACH);
  assign sel_epc = is_mach ? mepc_in : sepc_in;

  trp_gate #(.RULE_W(RULE_W)) u_gate (
    .kind_mach      (is_mach),
    .priv           (cur_priv),
    .virt           (cur_virt),
    .trap_sret      (mstatus_in[ST_TRAP_SRET]),
    .mach_pp        (mstatus_in[PP_HI:ST_MACH_PP]),
    .vtrap_sret     (hstatus_in[HY_VTRAP_SR]),
    .epc_lo         (sel_epc[1:0]),
    .cfg_compressed (cfg_compressed),
    .cfg_hyp        (cfg_hyp),
    .cfg_pmp        (cfg_pmp),
    .cfg_pmp_rules  (cfg_pmp_rules),
    .fault          (fault),
    .cause          (cause)
  );

  trp_sret_next #(.XLEN(XLEN)) u_sret (
    .ms           (mstatus_in),
    .hs           (hstatus_in),
    .virt         (cur_virt),
    .cfg_hyp      (cfg_hyp),
    .cfg_new_spec (cfg_new_spec),
    .ms_next      (s_ms),
    .hs_next      (s_hs),
    .priv_next    (s_priv),
    .virt_next    (s_virt),
    .swap         (s_swap)
  );

  trp_mret_next #(.XLEN(XLEN)) u_mret (
    .ms           (mstatus_in),
    .virt         (cur_virt),
    .cfg_hyp      (cfg_hyp),
    .cfg_new_spec (cfg_new_spec),
    .ms_next      (m_ms),
    .priv_next    (m_priv),
    .virt_next    (m_virt),
    .swap         (m_swap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ret_valid   <= 1'b0;
      ret_pc      <= '0;
      mstatus_out <= '0;
      hstatus_out <= '0;
      priv_out    <= PRIV_M;
      virt_out    <= 1'b0;
      swap_req    <= 1'b0;
      exc_valid   <= 1'b0;
      exc_cause   <= '0;
    end else begin
      ret_valid <= 1'b0;
      swap_req  <= 1'b0;
      exc_valid <= 1'b0;
      if (req_valid) begin
        if (fault) begin
          exc_valid   <= 1'b1;
          exc_cause   <= cause;
          mstatus_out <= mstatus_in;
          hstatus_out <= hstatus_in;
          priv_out    <= cur_priv;
          virt_out    <= cur_virt;
        end else begin
          ret_valid <= 1'b1;
          ret_pc    <= sel_epc;
          if (is_mach) begin
            mstatus_out <= m_ms;
            hstatus_out <= hstatus_in;
            priv_out    <= m_priv;
            virt_out    <= m_virt;
            swap_req    <= m_swap;
          end else begin
            mstatus_out <= s_ms;
            hstatus_out <= s_hs;
            priv_out    <= s_priv;
            virt_out    <= s_virt;
            swap_req    <= s_swap;
          end
        end
      end
    end
  end

endmodule

// File: rtl/trap_return_unit_chk.sv
module trap_return_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_kind,
  input logic [1:0]      cur_priv,
  input logic [XLEN-1:0] mstatus_in,
  input logic            ret_valid,
  input logic [XLEN-1:0] mstatus_out,
  input logic            swap_req,
  input logic            exc_valid,
  input logic [4:0]      exc_cause
);

  p_pulse_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(ret_valid && exc_valid));

  p_sret_user_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_kind && cur_priv == 2'd0) |=> (exc_valid && exc_cause == 5'd2));

  p_mret_priv_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind && cur_priv != 2'd3) |=> (exc_valid && exc_cause == 5'd2));

  p_exc_echo_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid) |=> (!exc_valid || mstatus_out == $past(mstatus_in)));

  p_mret_fields_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind) |=>
      (exc_valid || (mstatus_out[7] && mstatus_out[12:11] == 2'd0 && !mstatus_out[39])));

  p_swap_ok_r5: assert property (@(posedge clk) disable iff (rst)
    swap_req |-> ret_valid);

  p_idle_r13: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!ret_valid && !exc_valid && !swap_req));

endmodule

bind trap_return_unit trap_return_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_kind    (req_kind),
  .cur_priv    (cur_priv),
  .mstatus_in  (mstatus_in),
  .ret_valid   (ret_valid),
  .mstatus_out (mstatus_out),
  .swap_req    (swap_req),
  .exc_valid   (exc_valid),
  .exc_cause   (exc_cause)
);

// File: tb/trap_return_unit_bench.sv
module trap_return_unit_bench;

  localparam int XLEN   = 64;
  localparam int RULE_W = 7;

  typedef struct packed {
    logic        kind;
    logic [1:0]  priv;
    logic        virt;
    logic [63:0] ms;
    logic [63:0] hs;
    logic [63:0] pc;
    logic        comp;
    logic        hyp;
    logic        pmp;
    logic [6:0]  rules;
    logic        spec;
    logic        exc;
    logic [4:0]  cause;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd1, 1'b0, 64'h20120,       64'h0,      64'h1000, 1'b1, 1'b0, 1'b0, 7'd0, 1'b1, 1'b0, 5'd0,  8'd4},  // R4
    '{1'b0, 2'd0, 1'b0, 64'h0,           64'h0,      64'h1000, 1'b1, 1'b0, 1'b0, 7'd0, 1'b1, 1'b1, 5'd2,  8'd1},  // R1
    '{1'b0, 2'd1, 1'b0, 64'h0,           64'h0,      64'h1002, 1'b0, 1'b0, 1'b0, 7'd0, 1'b1, 1'b1, 5'd0,  8'd2},  // R2
    '{1'b0, 2'd1, 1'b0, 64'h22,          64'h0,      64'h1002, 1'b1, 1'b0, 1'b0, 7'd0, 1'b0, 1'b0, 5'd0,  8'd2},  // R2 compressed
    '{1'b0, 2'd1, 1'b0, 64'h400000,      64'h0,      64'h1000, 1'b1, 1'b0, 1'b0, 7'd0, 1'b1, 1'b1, 5'd2,  8'd3},  // R3
    '{1'b0, 2'd3, 1'b0, 64'h400100,      64'h0,      64'h1000, 1'b1, 1'b0, 1'b0, 7'd0, 1'b1, 1'b0, 5'd0,  8'd3},  // R3 machine
    '{1'b0, 2'd1, 1'b1, 64'h0,           64'h400000, 64'h1000, 1'b1, 1'b1, 1'b0, 7'd0, 1'b1, 1'b1, 5'd22, 8'd3},  // R3 virtual
    '{1'b0, 2'd1, 1'b0, 64'h100,         64'h80,     64'h1004, 1'b1, 1'b1, 1'b0, 7'd0, 1'b1, 1'b0, 5'd0,  8'd5},  // R5
    '{1'b0, 2'd1, 1'b1, 64'h0,           64'h80,     64'h1000, 1'b1, 1'b1, 1'b0, 7'd0, 1'b1, 1'b0, 5'd0,  8'd5},  // R5 virt on
    '{1'b0, 2'd0, 1'b0, 64'h0,           64'h0,      64'h1003, 1'b0, 1'b0, 1'b0, 7'd0, 1'b1, 1'b1, 5'd2,  8'd1},  // R1 over R2
    '{1'b1, 2'd1, 1'b0, 64'h0,           64'h0,      64'h2000, 1'b1, 1'b0, 1'b0, 7'd0, 1'b1, 1'b1, 5'd2,  8'd6},  // R6
    '{1'b1, 2'd3, 1'b0, 64'h8000020880,  64'h0,      64'h2000, 1'b1, 1'b1, 1'b0, 7'd0, 1'b1, 1'b0, 5'd0,  8'd9},  // R9 R8
    '{1'b1, 2'd3, 1'b0, 64'h21800,       64'h0,      64'h2000, 1'b1, 1'b0, 1'b0, 7'd0, 1'b1, 1'b0, 5'd0,  8'd8},  // R8 keep
    '{1'b1, 2'd3, 1'b0, 64'h20800,       64'h0,      64'h2000, 1'b1, 1'b0, 1'b0, 7'd0, 1'b0, 1'b0, 5'd0,  8'd8},  // R8 old spec
    '{1'b1, 2'd3, 1'b0, 64'h0,           64'h0,      64'h2000, 1'b1, 1'b0, 1'b1, 7'd0, 1'b1, 1'b1, 5'd1,  8'd10}, // R10
    '{1'b1, 2'd3, 1'b0, 64'h1800,        64'h0,      64'h2000, 1'b1, 1'b0, 1'b1, 7'd0, 1'b1, 1'b0, 5'd0,  8'd10}, // R10 machine pp
    '{1'b1, 2'd3, 1'b0, 64'h0,           64'h0,      64'h2000, 1'b1, 1'b0, 1'b1, 7'd2, 1'b1, 1'b0, 5'd0,  8'd10}, // R10 rules
    '{1'b1, 2'd3, 1'b0, 64'h0,           64'h0,      64'h2001, 1'b0, 1'b0, 1'b1, 7'd0, 1'b1, 1'b1, 5'd0,  8'd2},  // R2 over R10
    '{1'b1, 2'd3, 1'b0, 64'h8000000000,  64'h0,      64'h2000, 1'b1, 1'b0, 1'b0, 7'd0, 1'b1, 1'b0, 5'd0,  8'd9},  // R9 no hyp
    '{1'b0, 2'd1, 1'b1, 64'h400000,      64'h400000, 64'h1000, 1'b1, 1'b1, 1'b0, 7'd0, 1'b1, 1'b1, 5'd2,  8'd3},  // R3 order
    '{1'b1, 2'd3, 1'b1, 64'h1800,        64'h0,      64'h2000, 1'b1, 1'b1, 1'b0, 7'd0, 1'b1, 1'b0, 5'd0,  8'd9},  // R9 leave virt
    '{1'b1, 2'd3, 1'b0, 64'h8,           64'h0,      64'h2000, 1'b1, 1'b0, 1'b0, 7'd0, 1'b1, 1'b0, 5'd0,  8'd7}   // R7
  };

  logic              clk = 1'b0;
  logic              rst;
  logic              req_valid;
  logic              req_kind;
  logic [1:0]        cur_priv;
  logic              cur_virt;
  logic [XLEN-1:0]   mstatus_in, hstatus_in, mepc_in, sepc_in;
  logic              cfg_compressed, cfg_hyp, cfg_pmp, cfg_new_spec;
  logic [RULE_W-1:0] cfg_pmp_rules;
  logic              ret_valid, virt_out, swap_req, exc_valid;
  logic [XLEN-1:0]   ret_pc, mstatus_out, hstatus_out;
  logic [1:0]        priv_out;
  logic [4:0]        exc_cause;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  trap_return_unit #(.XLEN(XLEN), .RULE_W(RULE_W)) u_trap_return_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .cur_priv(cur_priv), .cur_virt(cur_virt), .mstatus_in(mstatus_in),
    .hstatus_in(hstatus_in), .mepc_in(mepc_in), .sepc_in(sepc_in),
    .cfg_compressed(cfg_compressed), .cfg_hyp(cfg_hyp), .cfg_pmp(cfg_pmp),
    .cfg_pmp_rules(cfg_pmp_rules), .cfg_new_spec(cfg_new_spec),
    .ret_valid(ret_valid), .ret_pc(ret_pc), .mstatus_out(mstatus_out),
    .hstatus_out(hstatus_out), .priv_out(priv_out), .virt_out(virt_out),
    .swap_req(swap_req), .exc_valid(exc_valid), .exc_cause(exc_cause)
  );

  task automatic chk(input bit ok, input int req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    req_valid      = 1'b1;
    req_kind       = v.kind;
    cur_priv       = v.priv;
    cur_virt       = v.virt;
    mstatus_in     = v.ms;
    hstatus_in     = v.hs;
    mepc_in        = v.kind ? v.pc : (v.pc ^ 64'h40);
    sepc_in        = v.kind ? (v.pc ^ 64'h40) : v.pc;
    cfg_compressed = v.comp;
    cfg_hyp        = v.hyp;
    cfg_pmp        = v.pmp;
    cfg_pmp_rules  = v.rules;
    cfg_new_spec   = v.spec;
  endtask

  // Expected outputs from the requirements; called at the negedge after the capture edge
  task automatic expect_vec(input vec_t v, input int idx);
    logic [63:0] em, eh;
    logic [1:0]  ep;
    logic        ev, es;
    string       tag;
    tag = $sformatf("vec %0d", idx);
    em = v.ms; eh = v.hs; ep = v.priv; ev = v.virt; es = 1'b0;
    if (!v.exc) begin
      if (!v.kind) begin
        em[1] = v.ms[5]; em[5] = 1'b1; em[8] = 1'b0;
        if (v.spec) em[17] = 1'b0;
        ep = {1'b0, v.ms[8]};
        if (v.hyp && !v.virt) begin
          ev = v.hs[7]; eh[7] = 1'b0; es = v.hs[7];
        end
      end else begin
        em[3] = v.ms[7]; em[7] = 1'b1; em[12:11] = 2'd0; em[39] = 1'b0;
        if (v.spec && v.ms[12:11] != 2'd3) em[17] = 1'b0;
        ep = v.ms[12:11];
        if (v.hyp) begin
          ev = v.ms[39]; es = v.ms[39];
        end
      end
    end
    chk(exc_valid == v.exc, int'(v.req), {tag, " exc_valid"}, 64'(exc_valid), 64'(v.exc));
    chk(ret_valid == !v.exc, int'(v.req), {tag, " ret_valid"}, 64'(ret_valid), 64'(!v.exc));
    if (v.exc)
      chk(exc_cause == v.cause, int'(v.req), {tag, " cause"}, 64'(exc_cause), 64'(v.cause));
    else
      chk(ret_pc == v.pc, int'(v.req), {tag, " ret_pc"}, ret_pc, v.pc);
    chk(mstatus_out == em, int'(v.req), {tag, " mstatus"}, mstatus_out, em);
    chk(hstatus_out == eh, int'(v.req), {tag, " hstatus"}, hstatus_out, eh);
    chk(priv_out == ep, int'(v.req), {tag, " priv"}, 64'(priv_out), 64'(ep));
    chk(virt_out == ev, int'(v.req), {tag, " virt"}, 64'(virt_out), 64'(ev));
    chk(swap_req == es, int'(v.req), {tag, " swap"}, 64'(swap_req), 64'(es));
  endtask

  task automatic check_reset_state();
    // R12
    chk(!ret_valid && !exc_valid && !swap_req, 12, "reset pulses",
        {61'd0, ret_valid, exc_valid, swap_req}, 64'd0);
    chk(priv_out == 2'd3, 12, "reset priv", 64'(priv_out), 64'd3);
    chk(mstatus_out == '0 && hstatus_out == '0 && ret_pc == '0 && !virt_out && exc_cause == '0,
        12, "reset values", mstatus_out | hstatus_out | ret_pc, 64'd0);
  endtask

  initial begin
    #(8 * 200000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [63:0] held;
    rst = 1'b1;
    drive(VECS[0]);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_reset_state();  // R12

    // Table walk: drive on a falling edge, captured on the next rising edge
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      req_valid = 1'b0;
      expect_vec(VECS[i], i);
    end

    // R13: inputs change without a request; outputs hold
    held = mstatus_out;
    drive(VECS[11]);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(!ret_valid && !exc_valid && !swap_req, 13, "idle pulses",
        {61'd0, ret_valid, exc_valid, swap_req}, 64'd0);
    chk(mstatus_out == held, 13, "idle hold", mstatus_out, held);

    // Back-to-back requests on consecutive cycles (R4 then R6)
    drive(VECS[0]);
    @(negedge clk);
    expect_vec(VECS[0], 100);
    drive(VECS[10]);
    @(negedge clk);
    req_valid = 1'b0;
    expect_vec(VECS[10], 101);

    // R11: pulse lasts one cycle
    @(negedge clk);
    chk(!exc_valid, 11, "exc one cycle", 64'(exc_valid), 64'd0);

    // R12: reset in mid-run
    drive(VECS[7]);
    @(negedge clk);
    req_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_reset_state();

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule